// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a simple request/done command port and an asynchronous static memory that has two chip enables of opposite polarity, per-byte lane controls and a pin that switches the array between 16-bit word organisation and 8-bit byte organisation. A request carries a write flag, a byte address, write data, byte enables and a byte-mode flag. The controller then sequences the memory strobes so that every minimum timing of the part is met, and it finishes each access with a one-cycle done pulse. For reads, the captured data is returned alongside that pulse.

All memory timings are parameters in nanoseconds. They are turned into clock counts by rounding up against a clock-period parameter, and every phase lasts at least one cycle. A write is controlled by the write-enable pulse. The sequence is: address and chip enables first, then a wait long enough for the memory to release the data bus, then the write-enable pulse with data driven. Write enable rises first and the data is held after it. Output enable stays high for the whole write. A read holds output enable low for the full read window and samples the bus on the clock edge that closes it.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset the chip is deselected (first chip enable high, second low), write enable and output enable are high, the data drivers are off, done is low and reqReady is high.
- R2: Write enable is high in both the cycle before and the cycle of any change of the memory address. In a write, the chip is selected with write enable high for at least ceil(T_HZ_NS/period) cycles (4 at defaults) before write enable falls.
- R3: Write enable stays low for at least max(ceil(T_WP_NS/period), ceil(T_DW_NS/period)) cycles (7 at defaults). The data drivers are on and the data is constant throughout.
- R4: In a write, the chip stays selected for at least ceil(T_WC_NS/period) cycles (9 at defaults). Data is still driven in the cycle after write enable rises.
- R5: Output enable is high whenever write enable is low. The data drivers turn on only after output enable has been high for at least ceil(T_HZ_NS/period) cycles, so the memory and the controller never drive the bus together.
- R6: A read keeps write enable high and output enable low for at least max of the read-cycle, address-access and output-enable-access times in cycles (9 at defaults). rdData holds the bus value sampled at the edge that ends that window.
- R7: In word mode (reqByteMode=0) the low and high lane controls are active-low copies of reqBe[0] and reqBe[1]. A write changes only the enabled lanes. Read lanes whose enable is 0 return zero.
- R8: In byte mode (reqByteMode=1) the mode pin memWide is 0 and memLowAddr equals reqAddr[0]. Both lane controls are low. Write data reqWdata[7:0] appears on memDout[7:0]. A read returns memDin[7:0] zero-extended to 16 bits.
- R9: Each accepted request gives exactly one done pulse, one cycle wide. A request is accepted only while reqReady is high, and reqValid raised while busy has no effect.
- R10: During an access memAddr equals reqAddr[ADDR_W:1], the word part of the byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W+1 | Byte address; bit 0 picks the byte in byte mode |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Lane enables for word mode |
| reqByteMode | input | 1 | 1 = 8-bit organisation for this access |
| reqReady | output | 1 | Controller idle, request may be issued |
| rdData | output | DATA_W | Read result, valid with done |
| done | output | 1 | One-cycle completion pulse |
| memAddr | output | ADDR_W | Word address to the memory |
| memLowAddr | output | 1 | Extra low address bit used in byte mode |
| memCe1N | output | 1 | Chip enable, active low |
| memCe2 | output | 1 | Chip enable, active high |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLbN | output | 1 | Low lane control, active low |
| memUbN | output | 1 | High lane control, active low |
| memWide | output | 1 | Organisation pin, 1 = 16-bit words |
| memDout | output | DATA_W | Data driven to the memory |
| memDoutEn | output | 1 | Enable of the controller's data drivers |
| memDin | input | DATA_W | Data returned by the memory |

## Verification
The bound checker watches the strobe ordering on every cycle. It covers write enable high around address changes, output enable high under a write pulse, driver turn-on only after the bus-release window, pulse, read and cycle lengths measured with saturating counters, data stability under the pulse and the one-cycle done. The bench's behavioural memory and scoreboard are the only way to show that data lands in the right lanes and bytes, that masked read lanes come back as zero, that byte mode addresses the right half-word, and that a request raised while busy leaves memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef struct packed {
    logic load;
    logic ceOn;
    logic weOn;
    logic oeOn;
    logic doutOn;
    logic capture;
  } ctrlStrobes_t;

  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_DW_NS = 30,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_HZ_NS = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output logic         done,
  output ctrlStrobes_t strobes
);

  localparam int HZ_CYC  = cyclesFor(T_HZ_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = maxOf(cyclesFor(T_WP_NS, CLK_PERIOD_NS), cyclesFor(T_DW_NS, CLK_PERIOD_NS));
  localparam int WC_CYC  = cyclesFor(T_WC_NS, CLK_PERIOD_NS);
  localparam int REC_CYC = (WC_CYC - HZ_CYC - WP_CYC > 1) ? (WC_CYC - HZ_CYC - WP_CYC) : 1;
  localparam int RD_CYC  = maxOf(maxOf(cyclesFor(T_RC_NS, CLK_PERIOD_NS), cyclesFor(T_AA_NS, CLK_PERIOD_NS)),
                                 cyclesFor(T_OE_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC = maxOf(maxOf(HZ_CYC, WP_CYC), maxOf(REC_CYC, RD_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WRECOV, ST_READ
  } ctrlState_t;

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] cnt, lastCnt;
  logic lastCyc;

  always_comb begin
    case (state)
      ST_WSETUP: lastCnt = CNT_W'(HZ_CYC - 1);
      ST_WPULSE: lastCnt = CNT_W'(WP_CYC - 1);
      ST_WRECOV: lastCnt = CNT_W'(REC_CYC - 1);
      ST_READ:   lastCnt = CNT_W'(RD_CYC - 1);
      default:   lastCnt = '0;
    endcase
  end

  assign lastCyc = (cnt == lastCnt);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (reqValid) stateNext = reqWrite ? ST_WSETUP : ST_READ;
      ST_WSETUP: if (lastCyc) stateNext = ST_WPULSE;
      ST_WPULSE: if (lastCyc) stateNext = ST_WRECOV;
      ST_WRECOV: if (lastCyc) stateNext = ST_IDLE;
      ST_READ:   if (lastCyc) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state != stateNext) cnt <= '0;
      else if (state != ST_IDLE) cnt <= cnt + 1'b1;
      done <= ((state == ST_WRECOV) || (state == ST_READ)) && lastCyc;
    end
  end

  always_comb begin
    strobes.load    = (state == ST_IDLE) && reqValid;
    strobes.capture = (state == ST_READ) && lastCyc;
    strobes.ceOn    = (stateNext != ST_IDLE);
    strobes.weOn    = (stateNext == ST_WPULSE);
    strobes.oeOn    = (stateNext == ST_READ);
    strobes.doutOn  = (stateNext == ST_WPULSE) || (stateNext == ST_WRECOV);
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          strobes,
  input  logic [ADDR_W:0]       reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqBe,
  input  logic                  reqByteMode,
  output logic [DATA_W-1:0]     rdData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memLowAddr,
  output logic                  memCe1N,
  output logic                  memCe2,
  output logic                  memOeN,
  output logic                  memWeN,
  output logic [DATA_W/8-1:0]   memLaneN,
  output logic                  memWide,
  output logic [DATA_W-1:0]     memDout,
  output logic                  memDoutEn,
  input  logic [DATA_W-1:0]     memDin
);

  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0]  beQ;
  logic              byteModeQ;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      memAddr    <= '0;
      memLowAddr <= 1'b0;
      memLaneN   <= '1;
      memWide    <= 1'b1;
      memDout    <= '0;
      beQ        <= '0;
      byteModeQ  <= 1'b0;
    end else if (strobes.load) begin
      memAddr    <= reqAddr[ADDR_W:1];
      memLowAddr <= reqByteMode ? reqAddr[0] : 1'b0;
      memLaneN   <= reqByteMode ? '0 : ~reqBe;
      memWide    <= ~reqByteMode;
      memDout    <= reqByteMode ? {LANES{reqWdata[7:0]}} : reqWdata;
      beQ        <= reqBe;
      byteModeQ  <= reqByteMode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memCe1N   <= 1'b1;
      memCe2    <= 1'b0;
      memWeN    <= 1'b1;
      memOeN    <= 1'b1;
      memDoutEn <= 1'b0;
    end else begin
      memCe1N   <= ~strobes.ceOn;
      memCe2    <= strobes.ceOn;
      memWeN    <= ~strobes.weOn;
      memOeN    <= ~strobes.oeOn;
      memDoutEn <= strobes.doutOn;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_low
      assign rdNext[7:0] = (byteModeQ || beQ[0]) ? memDin[7:0] : 8'h00;
    end else begin : g_high
      assign rdNext[l*8 +: 8] = (!byteModeQ && beQ[l]) ? memDin[l*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdData <= '0;
    else if (strobes.capture) rdData <= rdNext;
  end

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_DW_NS = 30,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_HZ_NS = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W:0]     reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic                reqByteMode,
  output logic                reqReady,
  output logic [DATA_W-1:0]   rdData,
  output logic                done,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memLowAddr,
  output logic                memCe1N,
  output logic                memCe2,
  output logic                memOeN,
  output logic                memWeN,
  output logic                memLbN,
  output logic                memUbN,
  output logic                memWide,
  output logic [DATA_W-1:0]   memDout,
  output logic                memDoutEn,
  input  logic [DATA_W-1:0]   memDin
);

  localparam int LANES = DATA_W / 8;

  ctrlStrobes_t     strobes;
  logic [LANES-1:0] laneN;

  sram_ctrl_fsm #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS),
    .T_DW_NS(T_DW_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
    .T_OE_NS(T_OE_NS), .T_HZ_NS(T_HZ_NS)
  ) u_fsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .done(done), .strobes(strobes)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .reqByteMode(reqByteMode),
    .rdData(rdData), .memAddr(memAddr), .memLowAddr(memLowAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memLaneN(laneN), .memWide(memWide), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[LANES-1];

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_DW_NS = 30,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_HZ_NS = 30
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCe2,
  input logic              memOeN,
  input logic              memWeN,
  input logic [DATA_W-1:0] memDout,
  input logic              memDoutEn,
  input logic              done,
  input logic              reqReady
);

  localparam int HZ_CYC = cyclesFor(T_HZ_NS, CLK_PERIOD_NS);
  localparam int WP_CYC = maxOf(cyclesFor(T_WP_NS, CLK_PERIOD_NS), cyclesFor(T_DW_NS, CLK_PERIOD_NS));
  localparam int WC_CYC = cyclesFor(T_WC_NS, CLK_PERIOD_NS);
  localparam int RD_CYC = maxOf(maxOf(cyclesFor(T_RC_NS, CLK_PERIOD_NS), cyclesFor(T_AA_NS, CLK_PERIOD_NS)),
                                cyclesFor(T_OE_NS, CLK_PERIOD_NS));

  logic [7:0] weLowCnt, oeLowCnt, oeHighCnt, ceOnCnt;
  logic       wroteQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      weLowCnt  <= '0;
      oeLowCnt  <= '0;
      oeHighCnt <= '0;
      ceOnCnt   <= '0;
      wroteQ    <= 1'b0;
    end else begin
      weLowCnt  <= memWeN ? 8'd0 : ((weLowCnt == 8'hFF) ? weLowCnt : weLowCnt + 8'd1);
      oeLowCnt  <= memOeN ? 8'd0 : ((oeLowCnt == 8'hFF) ? oeLowCnt : oeLowCnt + 8'd1);
      oeHighCnt <= !memOeN ? 8'd0 : ((oeHighCnt == 8'hFF) ? oeHighCnt : oeHighCnt + 8'd1);
      ceOnCnt   <= !memCe2 ? 8'd0 : ((ceOnCnt == 8'hFF) ? ceOnCnt : ceOnCnt + 8'd1);
      if (!memCe2) wroteQ <= 1'b0;
      else if (!memWeN) wroteQ <= 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!memCe2 && memWeN && memOeN && !memDoutEn && !done && reqReady));

  p_addr_we_high_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(memAddr) |-> (memWeN && $past(memWeN)));

  p_we_pulse_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (weLowCnt >= 8'(WP_CYC)));

  p_data_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && $past(!memWeN)) |-> (memDoutEn && $stable(memDout)));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (memDoutEn && $stable(memDout)));

  p_write_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(memCe2) && wroteQ) |-> (ceOnCnt >= 8'(WC_CYC)));

  p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> memOeN);

  p_bus_release_r5: assert property (@(posedge clk) disable iff (rst)
    memDoutEn |-> (memOeN && (oeHighCnt >= 8'(HZ_CYC))));

  p_read_we_high_r6: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> memWeN);

  p_read_len_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(memOeN) |-> (oeLowCnt >= 8'(RD_CYC)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (reqReady && !memCe2));

endmodule

bind sram_access_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS),
  .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS), .T_HZ_NS(T_HZ_NS)
) u_checker (
  .clk(clk), .rst(rst), .memAddr(memAddr), .memCe2(memCe2), .memOeN(memOeN),
  .memWeN(memWeN), .memDout(memDout), .memDoutEn(memDoutEn),
  .done(done), .reqReady(reqReady)
);

// File: tb/test_sram_access_ctrl.sv
`timescale 1ns/1ps
module test_sram_access_ctrl;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int HZ_EXP = 4;   // ceil(30/8)
  localparam int WP_EXP = 7;   // ceil(50/8)
  localparam int WC_EXP = 9;   // ceil(70/8)
  localparam int RD_EXP = 9;   // ceil(70/8)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqByteMode = 1'b0;
  logic [AW:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [1:0] reqBe = 2'b11;
  logic reqReady, done, memLowAddr, memCe1N, memCe2, memOeN, memWeN;
  logic memLbN, memUbN, memWide, memDoutEn;
  logic [DW-1:0] rdData, memDout, memDin;
  logic [AW-1:0] memAddr;

  always #4 clk = ~clk;

  sram_access_ctrl i_sram_access_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .reqByteMode(reqByteMode),
    .reqReady(reqReady), .rdData(rdData), .done(done),
    .memAddr(memAddr), .memLowAddr(memLowAddr), .memCe1N(memCe1N), .memCe2(memCe2),
    .memOeN(memOeN), .memWeN(memWeN), .memLbN(memLbN), .memUbN(memUbN),
    .memWide(memWide), .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  int total = 0;
  int bad = 0;

  function automatic void check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endfunction

  // behavioural memory
  logic [15:0] modelMem [0:255];
  logic [15:0] shadow   [0:255];
  logic selected, modelDrives;
  assign selected    = !memCe1N && memCe2;
  assign modelDrives = selected && !memOeN && memWeN;

  always_comb begin
    memDin = 16'h0000;
    if (modelDrives) begin
      if (memWide) memDin = modelMem[memAddr[7:0]];
      else memDin = {8'h00, memLowAddr ? modelMem[memAddr[7:0]][15:8] : modelMem[memAddr[7:0]][7:0]};
    end
  end

  always @(posedge memWeN) begin
    if (selected && !rst) begin
      if (memWide) begin
        if (!memLbN) modelMem[memAddr[7:0]][7:0]  = memDout[7:0];
        if (!memUbN) modelMem[memAddr[7:0]][15:8] = memDout[15:8];
      end else if (memLowAddr) modelMem[memAddr[7:0]][15:8] = memDout[7:0];
      else modelMem[memAddr[7:0]][7:0] = memDout[7:0];
    end
  end

  // scoreboard
  typedef struct { bit isRead; logic [15:0] expData; string tag; } item_t;
  item_t expQ[$];

  // pin monitor
  int weRun = 0, oeRun = 0, ceRun = 0, oeHighRun = 100;
  logic prevWeN = 1'b1, prevOeN = 1'b1, prevCe = 1'b0, prevDoutEn = 1'b0, wrote = 1'b0;
  logic [AW-1:0] prevAddr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (memAddr != prevAddr) check(memWeN && prevWeN, "R2 addr change with WE high", {31'd0, memWeN}, 32'd1);
      if (memDoutEn && modelDrives) check(1'b0, "R5 bus contention", 32'd1, 32'd0);
      if (!memWeN && prevWeN) check(ceRun >= HZ_EXP, "R2 setup before WE fall", ceRun, HZ_EXP);
      if (!memWeN) check(memOeN, "R5 OE high in write", {31'd0, memOeN}, 32'd1);
      if (memDoutEn && !prevDoutEn) check(oeHighRun >= HZ_EXP, "R5 driver turn-on delay", oeHighRun, HZ_EXP);
      if (memWeN && !prevWeN) begin
        check(weRun >= WP_EXP, "R3 WE pulse width", weRun, WP_EXP);
        check(memDoutEn, "R4 data held after WE rise", {31'd0, memDoutEn}, 32'd1);
      end
      if (memOeN && !prevOeN) check(oeRun >= RD_EXP, "R6 OE low window", oeRun, RD_EXP);
      if (!selected && prevCe && wrote) check(ceRun >= WC_EXP, "R4 write cycle length", ceRun, WC_EXP);
      if (done) begin
        if (expQ.size() == 0) check(1'b0, "R9 unexpected done", 32'd1, 32'd0);
        else begin
          item_t it;
          it = expQ.pop_front();
          if (it.isRead) check(rdData == it.expData, it.tag, rdData, it.expData);
          else check(1'b1, it.tag, 0, 0);
        end
      end
      weRun     = memWeN ? 0 : weRun + 1;
      oeRun     = memOeN ? 0 : oeRun + 1;
      oeHighRun = memOeN ? oeHighRun + 1 : 0;
      if (!selected) wrote = 1'b0; else if (!memWeN) wrote = 1'b1;
      ceRun     = selected ? ceRun + 1 : 0;
    end
    prevWeN = memWeN; prevOeN = memOeN; prevCe = selected;
    prevDoutEn = memDoutEn; prevAddr = memAddr;
  end

  task automatic issue(input bit wr, input logic [AW:0] a, input logic [15:0] d,
                       input logic [1:0] be, input bit bm);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be; reqByteMode = bm;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doWrite(input logic [AW:0] a, input logic [15:0] d, input logic [1:0] be, input bit bm);
    item_t it;
    logic [7:0] w;
    w = a[8:1];
    if (bm) begin
      if (a[0]) shadow[w][15:8] = d[7:0]; else shadow[w][7:0] = d[7:0];
    end else begin
      if (be[0]) shadow[w][7:0] = d[7:0];
      if (be[1]) shadow[w][15:8] = d[15:8];
    end
    it.isRead = 0; it.expData = 0; it.tag = "R9 write done";
    expQ.push_back(it);
    issue(1'b1, a, d, be, bm);
    while (memWeN) @(negedge clk);
    check(memAddr == a[AW:1], "R10 write address", memAddr, a[AW:1]);
    if (bm) begin
      check(!memWide && memLowAddr == a[0] && !memLbN && !memUbN, "R8 byte mode pins",
            {memWide, memLowAddr, memLbN, memUbN}, {1'b0, a[0], 2'b00});
      check(memDout[7:0] == d[7:0], "R8 byte data lane", memDout[7:0], d[7:0]);
    end else begin
      check(memWide && memLbN == !be[0] && memUbN == !be[1], "R7 lane controls",
            {memWide, memLbN, memUbN}, {1'b1, !be[0], !be[1]});
      check(memDout == d, "R3 write data", memDout, d);
    end
    waitDone();
  endtask

  task automatic doRead(input logic [AW:0] a, input logic [1:0] be, input bit bm, input string tag);
    item_t it;
    logic [15:0] word;
    word = shadow[a[8:1]];
    it.isRead = 1; it.tag = tag;
    if (bm) it.expData = {8'h00, a[0] ? word[15:8] : word[7:0]};
    else it.expData = {be[1] ? word[15:8] : 8'h00, be[0] ? word[7:0] : 8'h00};
    expQ.push_back(it);
    issue(1'b0, a, 16'h0, be, bm);
    check(!memOeN && memWeN, "R6 read strobes", {memOeN, memWeN}, 2'b01);
    check(memAddr == a[AW:1], "R10 read address", memAddr, a[AW:1]);
    waitDone();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 256; i++) begin modelMem[i] = 16'h0; shadow[i] = 16'h0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(memCe1N && !memCe2 && memWeN && memOeN && !memDoutEn && !done && reqReady,
          "R1 reset pins", {memCe1N, memCe2, memWeN, memOeN, memDoutEn, done, reqReady},
          7'b1011001);
    // word write and read
    doWrite(21'h20, 16'hA5C3, 2'b11, 1'b0);
    doRead(21'h20, 2'b11, 1'b0, "R6 word read back");
    // lane masking
    doWrite(21'h20, 16'h1234, 2'b01, 1'b0);
    doRead(21'h20, 2'b11, 1'b0, "R7 partial lane write");
    doRead(21'h20, 2'b10, 1'b0, "R7 masked read lane");
    // byte mode
    doWrite(21'h41, 16'h007E, 2'b00, 1'b1);
    doWrite(21'h40, 16'h0081, 2'b00, 1'b1);
    doRead(21'h40, 2'b11, 1'b0, "R8 bytes combined");
    doRead(21'h41, 2'b00, 1'b1, "R8 byte read high");
    doRead(21'h40, 2'b00, 1'b1, "R8 byte read low");
    // request while busy is ignored
    expQ.push_back('{1, 16'hA534, "R9 read during busy"});
    issue(1'b0, 21'h20, 16'h0, 2'b11, 1'b0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 21'h20; reqWdata = 16'hFFFF; reqBe = 2'b11; reqByteMode = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R9 busy not ready", {31'd0, reqReady}, 0);
    waitDone();
    doRead(21'h20, 2'b11, 1'b0, "R9 busy write ignored");
    // pattern sweep
    for (int k = 0; k < 8; k++) doWrite(21'((k * 37 + 3) << 1), 16'(k * 16'h1357 + 16'h0F0F), 2'b11, 1'b0);
    for (int k = 0; k < 8; k++) doRead(21'((k * 37 + 3) << 1), 2'b11, 1'b0, "R6 sweep read");
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9 all done seen", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule